// File: doc/BRIEF.md
# Test Access Port Controller

This block is the sequencing core of a boundary-scan test port. A sixteen-state machine is clocked by the test clock `tck`. On every rising edge it samples the mode input `tms` to choose its next state. From its state it decodes the level strobes that a neighbouring instruction register and data-register bank use on the rising edge: capture and shift for each path, and a test-logic reset. It also produces the update strobes, which are registered on the falling edge. The block does not contain the scan registers themselves or any instruction decoding.

The serial output is retimed. The bit that the selected register presents on `scan_in` is captured on the falling edge of `tck` and driven on `tdo`. An output enable goes active only while one of the two shift states is current. The pad outside the block turns `tdo_oe` low into high impedance.

The undriven mode input reads as logic 1. Because of this, an idle port settles in and stays in Test-Logic-Reset. An active-low asynchronous power-on reset `trst_n` also forces that state.

The states and their transitions are listed below as "state: tms=0 → …, tms=1 → …".

- Test-Logic-Reset: 0 → Run-Test-Idle, 1 → Test-Logic-Reset
- Run-Test-Idle: 0 → Run-Test-Idle, 1 → Select-DR
- Select-DR: 0 → Capture-DR, 1 → Select-IR
- Capture-DR: 0 → Shift-DR, 1 → Exit1-DR
- Shift-DR: 0 → Shift-DR, 1 → Exit1-DR
- Exit1-DR: 0 → Pause-DR, 1 → Update-DR
- Pause-DR: 0 → Pause-DR, 1 → Exit2-DR
- Exit2-DR: 0 → Shift-DR, 1 → Update-DR
- Update-DR: 0 → Run-Test-Idle, 1 → Select-DR
- Select-IR: 0 → Capture-IR, 1 → Test-Logic-Reset
- The IR path from Capture-IR to Update-IR follows the same pattern as the DR path.

Top module: `tap_ctrl`

## Requirements
- R1: `state_o` uses this 4-bit encoding:
  - Test-Logic-Reset=F, Run-Test-Idle=C, Select-DR=7, Capture-DR=6, Shift-DR=2, Exit1-DR=1, Pause-DR=3, Exit2-DR=0, Update-DR=5
  - Select-IR=4, Capture-IR=E, Shift-IR=A, Exit1-IR=9, Pause-IR=B, Exit2-IR=8, Update-IR=D
  
  While `trst_n` is low, `state_o` is F at once, without a clock edge.
- R2: On each rising `tck` edge, the DR-path states and Run-Test-Idle move to the successor listed above for the sampled `tms`.
- R3: The IR-path states and Test-Logic-Reset move as listed above. Select-IR with `tms`=1 goes back to Test-Logic-Reset.
- R4: Five consecutive rising edges with `tms`=1 bring the machine to Test-Logic-Reset from any of the 16 states.
- R5: `test_rst` is high exactly while the state is Test-Logic-Reset. The instruction register uses it to load the identification instruction.
- R6: `capture_dr`, `shift_dr`, `capture_ir` and `shift_ir` are each high exactly while the state is, respectively, Capture-DR, Shift-DR, Capture-IR or Shift-IR. At most one of these strobes and `test_rst` is high at any time.
- R7: `update_dr` (`update_ir`) rises on the falling edge of `tck` that occurs while the state is Update-DR (Update-IR). It falls on the first falling edge at which the state is something else.
- R8: `tdo_oe` changes only on falling edges of `tck`. After a falling edge it is high exactly when the current state is Shift-DR or Shift-IR, and it is low during `trst_n`.
- R9: While `tdo_oe` is high, `tdo` equals the value `scan_in` had at the most recent falling edge of `tck`.
- R10: With `tms` held at its undriven level of 1, the machine stays in Test-Logic-Reset and `test_rst` stays high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous power-on reset, active low |
| tms | input | 1 | Mode select, sampled on rising edge, default high |
| scan_in | input | 1 | Serial output of the currently selected register |
| state_o | output | 4 | Current controller state (debug) |
| test_rst | output | 1 | Test-logic reset / load identification instruction |
| capture_dr | output | 1 | Data register capture strobe |
| shift_dr | output | 1 | Data register shift strobe |
| update_dr | output | 1 | Data register update strobe (falling-edge) |
| capture_ir | output | 1 | Instruction register capture strobe |
| shift_ir | output | 1 | Instruction register shift strobe |
| update_ir | output | 1 | Instruction register update strobe (falling-edge) |
| tdo | output | 1 | Retimed serial output |
| tdo_oe | output | 1 | Output enable for `tdo`; low means high impedance |

## Verification
The assertions assume that `tms` is settled before each rising edge of `tck`. They also assume that `scan_in` is settled before each falling edge, and that `trst_n` is released away from either edge. The stimulus meets these assumptions by changing `tms`, `scan_in` and `trst_n` one time unit after a rising edge and at no other time. Each property starts counting from the release of `trst_n`. The stimulus therefore keeps `tms` at 1 across that release, so the machine's first visible edge leaves it in Test-Logic-Reset.

// File: rtl/tap_pkg.sv
package tap_pkg;

    localparam int STATE_W = 4;

    typedef enum logic [STATE_W-1:0] {
        ST_EXIT2_DR  = 4'h0,
        ST_EXIT1_DR  = 4'h1,
        ST_SHIFT_DR  = 4'h2,
        ST_PAUSE_DR  = 4'h3,
        ST_SEL_IR    = 4'h4,
        ST_UPDATE_DR = 4'h5,
        ST_CAPT_DR   = 4'h6,
        ST_SEL_DR    = 4'h7,
        ST_EXIT2_IR  = 4'h8,
        ST_EXIT1_IR  = 4'h9,
        ST_SHIFT_IR  = 4'hA,
        ST_PAUSE_IR  = 4'hB,
        ST_IDLE      = 4'hC,
        ST_UPDATE_IR = 4'hD,
        ST_CAPT_IR   = 4'hE,
        ST_RESET     = 4'hF
    } tap_state_e;

    typedef struct packed {
        logic test_rst;
        logic capture_dr;
        logic shift_dr;
        logic capture_ir;
        logic shift_ir;
        logic in_update_dr;
        logic in_update_ir;
        logic in_shift;
    } tap_strobe_t;

endpackage

// File: rtl/tap_next_state.sv
module tap_next_state
    import tap_pkg::*;
(
    input  tap_state_e cur_state,
    input  logic       tms,
    output tap_state_e nxt_state
);

    always_comb begin
        nxt_state = ST_RESET;
        unique case (cur_state)
            ST_RESET:     nxt_state = tms ? ST_RESET     : ST_IDLE;
            ST_IDLE:      nxt_state = tms ? ST_SEL_DR    : ST_IDLE;
            ST_SEL_DR:    nxt_state = tms ? ST_SEL_IR    : ST_CAPT_DR;
            ST_CAPT_DR:   nxt_state = tms ? ST_EXIT1_DR  : ST_SHIFT_DR;
            ST_SHIFT_DR:  nxt_state = tms ? ST_EXIT1_DR  : ST_SHIFT_DR;
            ST_EXIT1_DR:  nxt_state = tms ? ST_UPDATE_DR : ST_PAUSE_DR;
            ST_PAUSE_DR:  nxt_state = tms ? ST_EXIT2_DR  : ST_PAUSE_DR;
            ST_EXIT2_DR:  nxt_state = tms ? ST_UPDATE_DR : ST_SHIFT_DR;
            ST_UPDATE_DR: nxt_state = tms ? ST_SEL_DR    : ST_IDLE;
            ST_SEL_IR:    nxt_state = tms ? ST_RESET     : ST_CAPT_IR;
            ST_CAPT_IR:   nxt_state = tms ? ST_EXIT1_IR  : ST_SHIFT_IR;
            ST_SHIFT_IR:  nxt_state = tms ? ST_EXIT1_IR  : ST_SHIFT_IR;
            ST_EXIT1_IR:  nxt_state = tms ? ST_UPDATE_IR : ST_PAUSE_IR;
            ST_PAUSE_IR:  nxt_state = tms ? ST_EXIT2_IR  : ST_PAUSE_IR;
            ST_EXIT2_IR:  nxt_state = tms ? ST_UPDATE_IR : ST_SHIFT_IR;
            ST_UPDATE_IR: nxt_state = tms ? ST_SEL_DR    : ST_IDLE;
            default:      nxt_state = ST_RESET;
        endcase
    end

endmodule

// File: rtl/tap_strobe_decode.sv
module tap_strobe_decode
    import tap_pkg::*;
(
    input  tap_state_e  cur_state,
    output tap_strobe_t strobes
);

    always_comb begin
        strobes = '0;
        unique case (cur_state)
            ST_RESET:     strobes.test_rst     = 1'b1;
            ST_CAPT_DR:   strobes.capture_dr   = 1'b1;
            ST_SHIFT_DR: begin
                strobes.shift_dr = 1'b1;
                strobes.in_shift = 1'b1;
            end
            ST_UPDATE_DR: strobes.in_update_dr = 1'b1;
            ST_CAPT_IR:   strobes.capture_ir   = 1'b1;
            ST_SHIFT_IR: begin
                strobes.shift_ir = 1'b1;
                strobes.in_shift = 1'b1;
            end
            ST_UPDATE_IR: strobes.in_update_ir = 1'b1;
            default:      strobes = '0;
        endcase
    end

endmodule

// File: rtl/tap_fall_stage.sv
module tap_fall_stage (
    input  logic tck,
    input  logic trst_n,
    input  logic in_update_dr,
    input  logic in_update_ir,
    input  logic in_shift,
    input  logic scan_in,
    output logic update_dr,
    output logic update_ir,
    output logic tdo,
    output logic tdo_oe
);

    always_ff @(negedge tck or negedge trst_n) begin
        if (!trst_n) begin
            update_dr <= 1'b0;
            update_ir <= 1'b0;
            tdo       <= 1'b0;
            tdo_oe    <= 1'b0;
        end else begin
            update_dr <= in_update_dr;
            update_ir <= in_update_ir;
            tdo       <= scan_in;
            tdo_oe    <= in_shift;
        end
    end

endmodule

// File: rtl/tap_ctrl.sv
module tap_ctrl
    import tap_pkg::*;
(
    input  logic                tck,
    input  logic                trst_n,
    input  logic                tms,
    input  logic                scan_in,
    output logic [STATE_W-1:0]  state_o,
    output logic                test_rst,
    output logic                capture_dr,
    output logic                shift_dr,
    output logic                update_dr,
    output logic                capture_ir,
    output logic                shift_ir,
    output logic                update_ir,
    output logic                tdo,
    output logic                tdo_oe
);

    tap_state_e  state_q;
    tap_state_e  state_d;
    tap_strobe_t strb;

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) state_q <= ST_RESET;
        else         state_q <= state_d;
    end

    tap_next_state u_next (
        .cur_state (state_q),
        .tms       (tms),
        .nxt_state (state_d)
    );

    tap_strobe_decode u_dec (
        .cur_state (state_q),
        .strobes   (strb)
    );

    tap_fall_stage u_fall (
        .tck          (tck),
        .trst_n       (trst_n),
        .in_update_dr (strb.in_update_dr),
        .in_update_ir (strb.in_update_ir),
        .in_shift     (strb.in_shift),
        .scan_in      (scan_in),
        .update_dr    (update_dr),
        .update_ir    (update_ir),
        .tdo          (tdo),
        .tdo_oe       (tdo_oe)
    );

    always_comb begin
        state_o    = state_q;
        test_rst   = strb.test_rst;
        capture_dr = strb.capture_dr;
        shift_dr   = strb.shift_dr;
        capture_ir = strb.capture_ir;
        shift_ir   = strb.shift_ir;
    end

endmodule

// File: rtl/tap_ctrl_chk.sv
module tap_ctrl_chk
    import tap_pkg::*;
(
    input logic               tck,
    input logic               trst_n,
    input logic               tms,
    input logic [STATE_W-1:0] state_o,
    input logic               test_rst,
    input logic               capture_dr,
    input logic               shift_dr,
    input logic               update_dr,
    input logic               capture_ir,
    input logic               shift_ir,
    input logic               update_ir,
    input logic               tdo_oe
);

    logic [2:0] ones_cnt;

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n)             ones_cnt <= '0;
        else if (!tms)           ones_cnt <= '0;
        else if (ones_cnt != 3'd5) ones_cnt <= ones_cnt + 3'd1;
    end

    assert_five_ones_R4: assert property (@(posedge tck) disable iff (!trst_n)
        (ones_cnt == 3'd5) |-> (state_o == ST_RESET));

    assert_selir_exit_R3: assert property (@(posedge tck) disable iff (!trst_n)
        (state_o == ST_SEL_IR && tms) |=> (state_o == ST_RESET));

    assert_exit2_loop_R2: assert property (@(posedge tck) disable iff (!trst_n)
        (state_o == ST_EXIT2_DR && !tms) |=> (state_o == ST_SHIFT_DR));

    assert_rst_entry_R5: assert property (@(posedge tck) disable iff (!trst_n)
        $rose(test_rst) |-> $past(tms));

    assert_strobe_excl_R6: assert property (@(posedge tck) disable iff (!trst_n)
        $onehot0({test_rst, capture_dr, shift_dr, capture_ir, shift_ir}));

    assert_upd_dr_R7: assert property (@(posedge tck) disable iff (!trst_n)
        update_dr |-> (state_o == ST_UPDATE_DR));

    assert_upd_ir_R7: assert property (@(posedge tck) disable iff (!trst_n)
        update_ir |-> (state_o == ST_UPDATE_IR));

    assert_oe_shift_R8: assert property (@(posedge tck) disable iff (!trst_n)
        tdo_oe |-> (state_o == ST_SHIFT_DR || state_o == ST_SHIFT_IR));

endmodule

bind tap_ctrl tap_ctrl_chk u_chk (
    .tck        (tck),
    .trst_n     (trst_n),
    .tms        (tms),
    .state_o    (state_o),
    .test_rst   (test_rst),
    .capture_dr (capture_dr),
    .shift_dr   (shift_dr),
    .update_dr  (update_dr),
    .capture_ir (capture_ir),
    .shift_ir   (shift_ir),
    .update_ir  (update_ir),
    .tdo_oe     (tdo_oe)
);

// File: tb/tap_ctrl_tb_top.sv
`timescale 1ns/100ps
module tap_ctrl_tb_top;
    import tap_pkg::*;

    logic       tck = 1'b0;
    logic       trst_n = 1'b0;
    logic       tms = 1'b1;
    logic       scan_in = 1'b1;
    logic [3:0] state_o;
    logic test_rst, capture_dr, shift_dr, update_dr;
    logic capture_ir, shift_ir, update_ir, tdo, tdo_oe;

    int total = 0;
    int bad = 0;
    bit done = 0;

    tap_state_e exp_q[$];
    tap_state_e model_st = ST_RESET;
    tap_state_e mon_st = ST_RESET;

    always #2.5 tck = ~tck;

    tap_ctrl dut_i (
        .tck(tck), .trst_n(trst_n), .tms(tms), .scan_in(scan_in),
        .state_o(state_o), .test_rst(test_rst),
        .capture_dr(capture_dr), .shift_dr(shift_dr), .update_dr(update_dr),
        .capture_ir(capture_ir), .shift_ir(shift_ir), .update_ir(update_ir),
        .tdo(tdo), .tdo_oe(tdo_oe)
    );

    function automatic tap_state_e bench_next(tap_state_e s, logic m);
        case (s)
            ST_RESET:     return m ? ST_RESET     : ST_IDLE;
            ST_IDLE:      return m ? ST_SEL_DR    : ST_IDLE;
            ST_SEL_DR:    return m ? ST_SEL_IR    : ST_CAPT_DR;
            ST_CAPT_DR:   return m ? ST_EXIT1_DR  : ST_SHIFT_DR;
            ST_SHIFT_DR:  return m ? ST_EXIT1_DR  : ST_SHIFT_DR;
            ST_EXIT1_DR:  return m ? ST_UPDATE_DR : ST_PAUSE_DR;
            ST_PAUSE_DR:  return m ? ST_EXIT2_DR  : ST_PAUSE_DR;
            ST_EXIT2_DR:  return m ? ST_UPDATE_DR : ST_SHIFT_DR;
            ST_UPDATE_DR: return m ? ST_SEL_DR    : ST_IDLE;
            ST_SEL_IR:    return m ? ST_RESET     : ST_CAPT_IR;
            ST_CAPT_IR:   return m ? ST_EXIT1_IR  : ST_SHIFT_IR;
            ST_SHIFT_IR:  return m ? ST_EXIT1_IR  : ST_SHIFT_IR;
            ST_EXIT1_IR:  return m ? ST_UPDATE_IR : ST_PAUSE_IR;
            ST_PAUSE_IR:  return m ? ST_EXIT2_IR  : ST_PAUSE_IR;
            ST_EXIT2_IR:  return m ? ST_UPDATE_IR : ST_SHIFT_IR;
            default:      return m ? ST_SEL_DR    : ST_IDLE;
        endcase
    endfunction

    function automatic bit is_ir(tap_state_e s);
        return s inside {ST_SEL_IR, ST_CAPT_IR, ST_SHIFT_IR, ST_EXIT1_IR,
                         ST_PAUSE_IR, ST_EXIT2_IR, ST_UPDATE_IR, ST_RESET};
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    // driver: runs from posedge+1; sets tms and pushes the state expected after the next edge
    task automatic step(input logic m);
        tms = m;
        scan_in = ~scan_in ^ m;
        model_st = bench_next(model_st, m);
        exp_q.push_back(model_st);
        @(posedge tck);
        #1;
    endtask

    // tms path from Test-Logic-Reset to state with code k
    task automatic go_to(input int k);
        logic [7:0] bits;
        int len;
        case (k)
            'hC: begin bits = 8'b0;       len = 1; end
            'h7: begin bits = 8'b10;      len = 2; end
            'h6: begin bits = 8'b010;     len = 3; end
            'h2: begin bits = 8'b0010;    len = 4; end
            'h1: begin bits = 8'b1010;    len = 4; end
            'h3: begin bits = 8'b01010;   len = 5; end
            'h0: begin bits = 8'b101010;  len = 6; end
            'h5: begin bits = 8'b11010;   len = 5; end
            'h4: begin bits = 8'b110;     len = 3; end
            'hE: begin bits = 8'b0110;    len = 4; end
            'hA: begin bits = 8'b00110;   len = 5; end
            'h9: begin bits = 8'b10110;   len = 5; end
            'hB: begin bits = 8'b010110;  len = 6; end
            'h8: begin bits = 8'b1010110; len = 7; end
            'hD: begin bits = 8'b110110;  len = 6; end
            default: begin bits = 8'b0;   len = 0; end
        endcase
        for (int i = 0; i < len; i++) step(bits[i]);
        check(state_o == 4'(k), "R1", "navigate", state_o, k);
    endtask

    task automatic five_ones();
        for (int i = 0; i < 5; i++) step(1'b1);
        check(state_o == ST_RESET, "R4", "five ones", state_o, ST_RESET);
    endtask

    // monitor for rising-edge behaviour
    always @(posedge tck) begin
        #0.5;
        if (exp_q.size() > 0) begin
            tap_state_e e;
            e = exp_q.pop_front();
            mon_st = e;
            check(state_o == e, is_ir(e) ? "R3" : "R2", "next state", state_o, e);
            check(test_rst == (e == ST_RESET), "R5", "test_rst", test_rst, e == ST_RESET);
            check({capture_dr, shift_dr, capture_ir, shift_ir} ==
                  {e == ST_CAPT_DR, e == ST_SHIFT_DR, e == ST_CAPT_IR, e == ST_SHIFT_IR},
                  "R6", "cap/shift strobes",
                  {capture_dr, shift_dr, capture_ir, shift_ir},
                  {e == ST_CAPT_DR, e == ST_SHIFT_DR, e == ST_CAPT_IR, e == ST_SHIFT_IR});
        end
    end

    // monitor for falling-edge behaviour
    always @(negedge tck) begin
        #0.5;
        if (trst_n) begin
            check(update_dr == (mon_st == ST_UPDATE_DR), "R7", "update_dr",
                  update_dr, mon_st == ST_UPDATE_DR);
            check(update_ir == (mon_st == ST_UPDATE_IR), "R7", "update_ir",
                  update_ir, mon_st == ST_UPDATE_IR);
            check(tdo_oe == (mon_st inside {ST_SHIFT_DR, ST_SHIFT_IR}), "R8", "tdo_oe",
                  tdo_oe, mon_st inside {ST_SHIFT_DR, ST_SHIFT_IR});
            if (tdo_oe) check(tdo == scan_in, "R9", "tdo retime", tdo, scan_in);
        end
    end

    initial begin
        #1_000_000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge tck);
        #0.5;
        check(state_o == ST_RESET, "R1", "reset state", state_o, ST_RESET);
        check(tdo_oe == 1'b0, "R8", "oe in reset", tdo_oe, 0);
        #0.5;
        trst_n = 1'b1;
        @(posedge tck);
        #1;
        // R10: undriven tms keeps the machine in reset
        for (int i = 0; i < 8; i++) step(1'b1);
        check(state_o == ST_RESET && test_rst, "R10", "idle high tms",
              {test_rst, state_o}, {1'b1, 4'hF});
        // five-ones from every state, then each transition for both tms values
        for (int k = 0; k < 16; k++) begin
            go_to(k);
            five_ones();
            for (int b = 0; b < 2; b++) begin
                go_to(k);
                step(b[0]);
                five_ones();
            end
        end
        // long DR shift with pause and resume
        go_to('h2);
        for (int i = 0; i < 6; i++) step(1'b0);
        step(1'b1); step(1'b0); step(1'b0); step(1'b1); step(1'b0);
        for (int i = 0; i < 3; i++) step(1'b0);
        step(1'b1); step(1'b1); step(1'b0);
        check(state_o == ST_IDLE, "R2", "after DR scan", state_o, ST_IDLE);
        // asynchronous reset in the middle of an IR shift
        go_to('hA);
        step(1'b0);
        exp_q.delete();
        trst_n = 1'b0;
        tms = 1'b1;
        model_st = ST_RESET;
        mon_st = ST_RESET;
        #1;
        check(state_o == ST_RESET, "R1", "async reset", state_o, ST_RESET);
        check(tdo_oe == 1'b0, "R8", "oe async reset", tdo_oe, 0);
        repeat (2) @(posedge tck);
        #1;
        trst_n = 1'b1;
        @(posedge tck);
        #1;
        go_to('hE);
        step(1'b1); step(1'b1); step(1'b0);
        check(state_o == ST_IDLE, "R3", "after IR scan", state_o, ST_IDLE);
        repeat (2) @(posedge tck);
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule